// File: doc/BRIEF.md
# USB Host Controller Command and Status Core

This block is the control heart of a full/low-speed USB host controller. It holds the command register, the status register, the interrupt-enable mask, the 11-bit frame counter and the frame-list base. It turns a 1 kHz frame tick into frame advances. Software starts and stops the schedule through the run bit. The transfer engine that walks the schedule reads `frame_addr` to find the list entry for the current frame, and starts work only while `sched_run` is high.

During a frame the transfer engine reports completions as a two-bit cause: on-complete and short-packet. These causes are gathered in a pending mask. They become visible only at the next frame tick. At that tick they are ORed into a two-bit latch that software cannot see, and the status interrupt bit is raised. The completion input is a one-cycle valid strobe with no back-pressure: a beat is accepted in every cycle that `cmpl_valid` is high. Error, system-fault, process-fault and resume inputs are plain level-sampled pulses. Register access is a single-cycle write strobe with a combinational read of the selected register.

Top module: `usbh_ctl_core`

## Requirements
- R1: Register select codes are 0 command, 1 status, 2 interrupt enable, 3 frame number and 4 frame-list base. After reset, status reads 0x20 (halted), and command, enable, frame number, base, `frame_addr`, `irq` and `sched_run` are all 0.
- R2: The command bits are run at bit 0, host reset at bit 1, bus reset at bit 2, suspend at bit 3 and force-resume at bit 4. A write stores bits 0, 2, 3 and 4 and reads them back. Bit 1 is never stored.
- R3: Writing run as 1 while it is stored as 0 clears halted (status bit 5) and raises `sched_run`. Writing run as 0 sets halted at once. The next tick with run clear drops `sched_run`, sets halted and does not advance the frame.
- R4: Each tick while `sched_run` is high and run is set adds 1 to the 11-bit frame number, modulo 2048. A frame-number write keeps bits 10:0 and takes effect only while halted.
- R5: The base keeps write bits 31:12 and reads 0 below them. `frame_addr` equals the base plus 4 times frame-number bits 9:0.
- R6: Completion causes seen during a frame are committed only at the next advancing tick. A nonzero pending mask sets status bit 0. A cause that arrives in the same cycle as the tick belongs to the following frame.
- R7: `irq` is high when any of these holds: latched cause 0 with enable bit 2; latched cause 1 with enable bit 3; error status (bit 1) with enable bit 0; resume status (bit 2) with enable bit 1; host-error status (bit 3); process-error status (bit 4). The last two need no enable.
- R8: A resume event while suspend is set sets force-resume and status bit 2. A resume event without suspend is ignored.
- R9: Writing 1 to any of status bits 0 to 5 clears that bit. Clearing bit 0 also empties the latched causes. A hardware set in the same cycle as the clear wins.
- R10: Writing the command with bit 1 set returns every register to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| frame_tick | input | 1 | 1 kHz frame tick, one cycle wide |
| cmpl_valid | input | 1 | Completion beat valid, always accepted |
| cmpl_cause | input | 2 | Bit 0 on-complete, bit 1 short-packet |
| xfer_err | input | 1 | Transfer error pulse |
| host_sys_err | input | 1 | Host system error pulse |
| proc_err | input | 1 | Schedule process error pulse |
| resume_evt | input | 1 | Remote resume event pulse |
| frame_addr | output | 32 | Frame-list entry address |
| sched_run | output | 1 | Frame processing active |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can land in the same cycle. A completion beat can coincide with a frame tick; the beat must then wait one more frame. The bench drives both strobes in one cycle and expects status bit 0 to stay clear after that tick and to rise only after the next tick. A run-bit write can also meet the tick that stops the schedule. The bench writes run as 0 and then ticks, and it expects halted in both cycles and no frame advance on the stopping tick.

// File: rtl/usbh_ctl_pkg.sv
package usbh_ctl_pkg;
  typedef enum logic [2:0] {
    SEL_CMD   = 3'd0,
    SEL_STS   = 3'd1,
    SEL_IEN   = 3'd2,
    SEL_FNUM  = 3'd3,
    SEL_FBASE = 3'd4
  } reg_sel_e;

  localparam int CMD_W    = 5;
  localparam int CMD_RUN  = 0;
  localparam int CMD_HRST = 1;
  localparam int CMD_BRST = 2;
  localparam int CMD_SUSP = 3;
  localparam int CMD_FRES = 4;

  localparam int STS_W    = 6;
  localparam int STS_INT  = 0;
  localparam int STS_ERR  = 1;
  localparam int STS_RSM  = 2;
  localparam int STS_HSE  = 3;
  localparam int STS_PERR = 4;
  localparam int STS_HALT = 5;

  localparam int IEN_W    = 4;
  localparam int IEN_ERR  = 0;
  localparam int IEN_RSM  = 1;
  localparam int IEN_CMPL = 2;

  localparam int CAUSE_W  = 2;
endpackage

// File: rtl/usbh_cmd_stat.sv
module usbh_cmd_stat
  import usbh_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             sts_wr,
  input  logic [STS_W-1:0] sts_wdata,
  input  logic             frame_tick,
  input  logic             commit_int,
  input  logic             xfer_err,
  input  logic             host_sys_err,
  input  logic             proc_err,
  input  logic             resume_evt,
  output logic [CMD_W-1:0] cmd_q,
  output logic [STS_W-1:0] sts_q,
  output logic             running,
  output logic             tick_adv
);
  localparam logic [STS_W-1:0] STS_RST = STS_W'(1) << STS_HALT;

  logic [CMD_W-1:0] cmd_n;
  logic [STS_W-1:0] sts_n;
  logic             run_n;
  logic             tick_stop;

  assign tick_adv  = frame_tick & running & cmd_q[CMD_RUN];
  assign tick_stop = frame_tick & running & ~cmd_q[CMD_RUN];

  always_comb begin
    cmd_n = cmd_q;
    sts_n = sts_q;
    run_n = running;
    if (sts_wr) sts_n = sts_q & ~sts_wdata;
    if (tick_stop) begin
      run_n           = 1'b0;
      sts_n[STS_HALT] = 1'b1;
    end
    if (cmd_wr) begin
      cmd_n           = cmd_wdata;
      cmd_n[CMD_HRST] = 1'b0;
      if (cmd_wdata[CMD_RUN] && !cmd_q[CMD_RUN]) begin
        run_n           = 1'b1;
        sts_n[STS_HALT] = 1'b0;
      end else if (!cmd_wdata[CMD_RUN]) begin
        sts_n[STS_HALT] = 1'b1;
      end
    end
    if (commit_int)   sts_n[STS_INT]  = 1'b1;
    if (xfer_err)     sts_n[STS_ERR]  = 1'b1;
    if (host_sys_err) sts_n[STS_HSE]  = 1'b1;
    if (proc_err)     sts_n[STS_PERR] = 1'b1;
    if (resume_evt && cmd_q[CMD_SUSP]) begin
      sts_n[STS_RSM]  = 1'b1;
      cmd_n[CMD_FRES] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      sts_q   <= STS_RST;
      running <= 1'b0;
    end else if (soft_rst) begin
      cmd_q   <= '0;
      sts_q   <= STS_RST;
      running <= 1'b0;
    end else begin
      cmd_q   <= cmd_n;
      sts_q   <= sts_n;
      running <= run_n;
    end
  end

  AST_RUN_NOT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cmd_q[CMD_RUN]) |-> !sts_q[STS_HALT]); // R3

  AST_STOP_AT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (running && frame_tick && !cmd_q[CMD_RUN] && !cmd_wr && !soft_rst)
      |=> (!running && sts_q[STS_HALT])); // R3

  AST_RESUME_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_evt && cmd_q[CMD_SUSP] && !soft_rst)
      |=> (sts_q[STS_RSM] && cmd_q[CMD_FRES])); // R8
endmodule

// File: rtl/usbh_frame_ctr.sv
module usbh_frame_ctr #(
  parameter int DATA_W     = 32,
  parameter int FNUM_W     = 11,
  parameter int IDX_W      = 10,
  parameter int ENTRY_LOG2 = 2,
  parameter int BASE_LSB   = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       soft_rst,
  input  logic                       tick_adv,
  input  logic                       halted,
  input  logic                       fnum_wr,
  input  logic [FNUM_W-1:0]          fnum_wdata,
  input  logic                       base_wr,
  input  logic [DATA_W-BASE_LSB-1:0] base_wdata,
  output logic [FNUM_W-1:0]          fnum_q,
  output logic [DATA_W-BASE_LSB-1:0] base_q,
  output logic [DATA_W-1:0]          frame_addr
);
  localparam int OFF_W = IDX_W + ENTRY_LOG2;

  logic [DATA_W-1:0] entry_off;

  assign entry_off  = {{(DATA_W-OFF_W){1'b0}}, fnum_q[IDX_W-1:0], {ENTRY_LOG2{1'b0}}};
  assign frame_addr = {base_q, {BASE_LSB{1'b0}}} + entry_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fnum_q <= '0;
      base_q <= '0;
    end else if (soft_rst) begin
      fnum_q <= '0;
      base_q <= '0;
    end else begin
      if (tick_adv)                fnum_q <= fnum_q + 1'b1;
      else if (fnum_wr && halted)  fnum_q <= fnum_wdata;
      if (base_wr)                 base_q <= base_wdata;
    end
  end

  AST_FNUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_adv && !soft_rst) |=> (fnum_q == FNUM_W'($past(fnum_q) + 1'b1))); // R4

  AST_FNUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_adv && !soft_rst && !(fnum_wr && halted)) |=> $stable(fnum_q)); // R4
endmodule

// File: rtl/usbh_irq_gen.sv
module usbh_irq_gen
  import usbh_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               ien_wr,
  input  logic [IEN_W-1:0]   ien_wdata,
  input  logic               cmpl_valid,
  input  logic [CAUSE_W-1:0] cmpl_cause,
  input  logic               commit,
  input  logic               clr_causes,
  input  logic [STS_W-1:0]   sts_q,
  output logic [IEN_W-1:0]   ien_q,
  output logic               commit_int,
  output logic               irq
);
  logic [CAUSE_W-1:0] pend_q, hid_q, beat, pend_n, hid_n;
  logic               irq_c;

  assign beat       = cmpl_valid ? cmpl_cause : '0;
  assign commit_int = commit & (|pend_q);

  always_comb begin
    pend_n = commit ? beat : (pend_q | beat);
    hid_n  = (clr_causes ? '0 : hid_q) | (commit_int ? pend_q : '0);
  end

  always_comb begin
    irq_c = (sts_q[STS_ERR] & ien_q[IEN_ERR]) | (sts_q[STS_RSM] & ien_q[IEN_RSM])
          | sts_q[STS_HSE] | sts_q[STS_PERR];
    for (int i = 0; i < CAUSE_W; i++) irq_c = irq_c | (hid_q[i] & ien_q[IEN_CMPL+i]);
  end
  assign irq = irq_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      hid_q  <= '0;
      ien_q  <= '0;
    end else if (soft_rst) begin
      pend_q <= '0;
      hid_q  <= '0;
      ien_q  <= '0;
    end else begin
      pend_q <= pend_n;
      hid_q  <= hid_n;
      if (ien_wr) ien_q <= ien_wdata;
    end
  end

  AST_COMMIT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && (|pend_q) && !soft_rst) |=> (|hid_q)); // R6

  AST_PEND_EMPTIED: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !cmpl_valid && !soft_rst) |=> (pend_q == '0)); // R6

  AST_NO_EARLY_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && (hid_q == '0) && !soft_rst) |=> (hid_q == '0)); // R6
endmodule

// File: rtl/usbh_ctl_core.sv
module usbh_ctl_core
  import usbh_ctl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FNUM_W     = 11,
  parameter int IDX_W      = 10,
  parameter int ENTRY_LOG2 = 2,
  parameter int BASE_LSB   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frame_tick,
  input  logic              cmpl_valid,
  input  logic [1:0]        cmpl_cause,
  input  logic              xfer_err,
  input  logic              host_sys_err,
  input  logic              proc_err,
  input  logic              resume_evt,
  output logic [DATA_W-1:0] frame_addr,
  output logic              sched_run,
  output logic              irq
);
  localparam int BASE_W = DATA_W - BASE_LSB;

  logic               cmd_wr, sts_wr, ien_wr, fnum_wr, base_wr, soft_rst;
  logic [CMD_W-1:0]   cmd_q;
  logic [STS_W-1:0]   sts_q;
  logic [IEN_W-1:0]   ien_q;
  logic [FNUM_W-1:0]  fnum_q;
  logic [BASE_W-1:0]  base_q;
  logic               running, tick_adv, commit_int;
  logic               unused_wdata;

  assign cmd_wr   = reg_wr && (reg_sel == SEL_CMD);
  assign sts_wr   = reg_wr && (reg_sel == SEL_STS);
  assign ien_wr   = reg_wr && (reg_sel == SEL_IEN);
  assign fnum_wr  = reg_wr && (reg_sel == SEL_FNUM);
  assign base_wr  = reg_wr && (reg_sel == SEL_FBASE);
  assign soft_rst = cmd_wr && reg_wdata[CMD_HRST];
  assign unused_wdata = ^reg_wdata;

  usbh_cmd_stat u_cmd_stat (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cmd_wr(cmd_wr), .cmd_wdata(reg_wdata[CMD_W-1:0]),
    .sts_wr(sts_wr), .sts_wdata(reg_wdata[STS_W-1:0]),
    .frame_tick(frame_tick), .commit_int(commit_int),
    .xfer_err(xfer_err), .host_sys_err(host_sys_err), .proc_err(proc_err),
    .resume_evt(resume_evt),
    .cmd_q(cmd_q), .sts_q(sts_q), .running(running), .tick_adv(tick_adv)
  );

  usbh_frame_ctr #(
    .DATA_W(DATA_W), .FNUM_W(FNUM_W), .IDX_W(IDX_W),
    .ENTRY_LOG2(ENTRY_LOG2), .BASE_LSB(BASE_LSB)
  ) u_frame_ctr (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick_adv(tick_adv),
    .halted(sts_q[STS_HALT]),
    .fnum_wr(fnum_wr), .fnum_wdata(reg_wdata[FNUM_W-1:0]),
    .base_wr(base_wr), .base_wdata(reg_wdata[DATA_W-1:BASE_LSB]),
    .fnum_q(fnum_q), .base_q(base_q), .frame_addr(frame_addr)
  );

  usbh_irq_gen u_irq_gen (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .ien_wr(ien_wr), .ien_wdata(reg_wdata[IEN_W-1:0]),
    .cmpl_valid(cmpl_valid), .cmpl_cause(cmpl_cause),
    .commit(tick_adv), .clr_causes(sts_wr && reg_wdata[STS_INT]),
    .sts_q(sts_q), .ien_q(ien_q), .commit_int(commit_int), .irq(irq)
  );

  assign sched_run = running;

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CMD:   reg_rdata = {{(DATA_W-CMD_W){1'b0}}, cmd_q};
      SEL_STS:   reg_rdata = {{(DATA_W-STS_W){1'b0}}, sts_q};
      SEL_IEN:   reg_rdata = {{(DATA_W-IEN_W){1'b0}}, ien_q};
      SEL_FNUM:  reg_rdata = {{(DATA_W-FNUM_W){1'b0}}, fnum_q};
      SEL_FBASE: reg_rdata = {base_q, {BASE_LSB{1'b0}}};
      default:   reg_rdata = '0;
    endcase
  end

  AST_HRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (sts_q[STS_HALT] && !running && cmd_q == '0 && fnum_q == '0)); // R10
endmodule

// File: tb/usbh_ctl_core_bench.sv
module usbh_ctl_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frame_tick = 1'b0, cmpl_valid = 1'b0;
  logic [1:0]  cmpl_cause = '0;
  logic        xfer_err = 1'b0, host_sys_err = 1'b0, proc_err = 1'b0, resume_evt = 1'b0;
  logic [31:0] frame_addr;
  logic        sched_run, irq;

  always #4 clk = ~clk;

  usbh_ctl_core u_usbh_ctl_core (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_tick(frame_tick),
    .cmpl_valid(cmpl_valid), .cmpl_cause(cmpl_cause), .xfer_err(xfer_err),
    .host_sys_err(host_sys_err), .proc_err(proc_err), .resume_evt(resume_evt),
    .frame_addr(frame_addr), .sched_run(sched_run), .irq(irq)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;

  // monitor: pops one expected item per cycle and compares at the falling edge
  initial begin
    exp_t        e;
    logic [31:0] act;
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        case (e.kind)
          0:       act = reg_rdata;
          1:       act = {31'b0, irq};
          2:       act = frame_addr;
          default: act = {31'b0, sched_run};
        endcase
        n_cmp++;
        if (act !== e.exp) begin
          n_bad++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", e.tag, act, e.exp);
        end
      end
    end
  end

  task automatic push(input int k, input logic [31:0] x, input string t);
    sbq.push_back('{k, x, t});
    wait (sbq.size() == 0);
  endtask

  task automatic rd(input logic [2:0] s, input logic [31:0] x, input string t);
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_sel = s;
    push(0, x, t);
  endtask

  task automatic see(input int k, input logic [31:0] x, input string t);
    @(posedge clk); #1;
    push(k, x, t);
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(posedge clk); #1;
    reg_sel = s; reg_wr = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  // which: 0 tick, 1 completion, 2 xfer err, 3 host err, 4 proc err, 5 resume, 6 tick+completion
  task automatic pulse(input int which, input logic [1:0] c);
    @(posedge clk); #1;
    cmpl_cause = c;
    case (which)
      0: frame_tick = 1'b1;
      1: cmpl_valid = 1'b1;
      2: xfer_err = 1'b1;
      3: host_sys_err = 1'b1;
      4: proc_err = 1'b1;
      5: resume_evt = 1'b1;
      default: begin frame_tick = 1'b1; cmpl_valid = 1'b1; end
    endcase
    @(posedge clk); #1;
    frame_tick = 1'b0; cmpl_valid = 1'b0; xfer_err = 1'b0;
    host_sys_err = 1'b0; proc_err = 1'b0; resume_evt = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(3'd1, 32'h20, "R1 status reset");
    rd(3'd0, 32'h0, "R1 command reset");
    rd(3'd3, 32'h0, "R1 frame number reset");
    see(2, 32'h0, "R1 frame_addr reset");
    see(1, 32'h0, "R1 irq reset");
    see(3, 32'h0, "R1 sched_run reset");
    // R5 base and entry address
    wr(3'd4, 32'h1234_5FFF);
    rd(3'd4, 32'h1234_5000, "R5 base low bits dropped");
    wr(3'd3, 32'h0000_FFFF);
    rd(3'd3, 32'h7FF, "R4 frame number keeps 11 bits");
    see(2, 32'h1234_5FFC, "R5 entry address");
    // R3 start
    wr(3'd0, 32'h1);
    rd(3'd1, 32'h0, "R3 halted cleared on start");
    see(3, 32'h1, "R3 sched_run on start");
    wr(3'd3, 32'h5);
    rd(3'd3, 32'h7FF, "R4 write ignored while running");
    pulse(0, 2'b00);
    rd(3'd3, 32'h0, "R4 wrap at 2048");
    see(2, 32'h1234_5000, "R5 address after wrap");
    // R6 / R7 on-complete cause
    wr(3'd2, 32'h4);
    pulse(1, 2'b01);
    rd(3'd1, 32'h0, "R6 not visible before tick");
    see(1, 32'h0, "R6 no irq before tick");
    pulse(0, 2'b00);
    rd(3'd1, 32'h1, "R6 committed at tick");
    see(1, 32'h1, "R7 on-complete cause enabled");
    wr(3'd1, 32'h1);
    rd(3'd1, 32'h0, "R9 interrupt bit cleared");
    see(1, 32'h0, "R9 latched causes emptied");
    // short-packet cause separated
    wr(3'd2, 32'h8);
    pulse(1, 2'b10);
    pulse(0, 2'b00);
    rd(3'd1, 32'h1, "R6 short cause committed");
    see(1, 32'h1, "R7 short cause enabled");
    wr(3'd2, 32'h4);
    see(1, 32'h0, "R7 causes kept apart");
    wr(3'd1, 32'h1);
    // collision: completion in the tick cycle
    pulse(6, 2'b01);
    rd(3'd1, 32'h0, "R6 same-cycle completion deferred");
    pulse(0, 2'b00);
    rd(3'd1, 32'h1, "R6 deferred completion committed");
    see(1, 32'h1, "R7 deferred cause raises irq");
    wr(3'd1, 32'h1);
    rd(3'd3, 32'h4, "R4 frame count after five ticks");
    // error sources
    wr(3'd2, 32'h0);
    pulse(2, 2'b00);
    rd(3'd1, 32'h2, "R7 error status set");
    see(1, 32'h0, "R7 error masked");
    wr(3'd2, 32'h1);
    see(1, 32'h1, "R7 error enabled");
    wr(3'd1, 32'h2);
    see(1, 32'h0, "R9 error cleared");
    wr(3'd2, 32'h0);
    pulse(3, 2'b00);
    see(1, 32'h1, "R7 host error needs no enable");
    wr(3'd1, 32'h8);
    see(1, 32'h0, "R9 host error cleared");
    pulse(4, 2'b00);
    rd(3'd1, 32'h10, "R7 process error status");
    see(1, 32'h1, "R7 process error needs no enable");
    wr(3'd1, 32'h10);
    // R8 resume
    pulse(5, 2'b00);
    rd(3'd1, 32'h0, "R8 resume ignored without suspend");
    rd(3'd0, 32'h1, "R8 command unchanged without suspend");
    wr(3'd0, 32'h9);
    rd(3'd0, 32'h9, "R2 command readback");
    pulse(5, 2'b00);
    rd(3'd0, 32'h19, "R8 force resume set");
    rd(3'd1, 32'h4, "R8 resume detect set");
    wr(3'd2, 32'h2);
    see(1, 32'h1, "R7 resume enabled");
    wr(3'd1, 32'h4);
    wr(3'd2, 32'h0);
    // R3 stop
    wr(3'd0, 32'h0);
    rd(3'd1, 32'h20, "R3 halted on stop write");
    see(3, 32'h1, "R3 runs until next tick");
    pulse(0, 2'b00);
    see(3, 32'h0, "R3 stopped at tick");
    rd(3'd1, 32'h20, "R3 halted after stop tick");
    rd(3'd3, 32'h4, "R3 no advance on stop tick");
    pulse(0, 2'b00);
    rd(3'd3, 32'h4, "R4 no advance while halted");
    wr(3'd3, 32'h3);
    see(2, 32'h1234_500C, "R5 address after frame write");
    wr(3'd1, 32'h20);
    rd(3'd1, 32'h0, "R9 halted cleared by write");
    // R10 host reset
    wr(3'd2, 32'hF);
    pulse(3, 2'b00);
    wr(3'd0, 32'h0000_000E);
    rd(3'd0, 32'h0, "R10 command reset");
    rd(3'd1, 32'h20, "R10 status reset");
    rd(3'd2, 32'h0, "R10 enable reset");
    rd(3'd3, 32'h0, "R10 frame number reset");
    rd(3'd4, 32'h0, "R10 base reset");
    see(1, 32'h0, "R10 irq low");
    see(3, 32'h0, "R10 not running");
    done = 1;
    summary();
    $finish;
  end
endmodule